// File: doc/BRIEF.md
# Direct-Access File Mask and Seek Validator

This block keeps the file mask that governs one command chain on a direct-access storage device. It checks every seek request and every write command against that mask. Channel control logic presents one command per cycle with its code, byte count, six-byte seek argument and candidate mask byte. One cycle later the block answers with a permit or reject decision and a status word. It also tracks the cylinder and head that accepted seeks have selected.

A chain-start strobe clears the mask, and the first set-mask command of the chain may then load a new one. The mask holds two fields. One decides which classes of write may run. The other decides which kinds of seek may move the access arm or switch heads. A seek argument is accepted only when all six bytes are well formed and the cylinder and head lie within the device limits on the geometry inputs. Any rejection raises unit check and leaves the position untouched.

Top module: `fms_validator`

## Requirements
- R1: After reset, cur_cyl and cur_head are 0, resp_valid is 0 and the mask is 0x00.
- R2: A command presented with cmd_valid high at a rising edge is answered at the next rising edge: resp_valid is high for exactly that one cycle and is low in every cycle that follows a cycle with no command.
- R3: chain_start clears the mask to 0x00 and re-arms the set-mask command. A command presented in the same cycle as chain_start is judged against the cleared state.
- R4: A set-mask command (code 0x1F, mask taken from mask_in) that comes after a successful one in the same chain is rejected, and the mask keeps its earlier value.
- R5: A set-mask command with mask_in[5] or mask_in[1] set is rejected and leaves the mask unchanged.
- R6: The write field is mask[7:6]. 00 rejects write-R0 (0x15). 01 rejects every write (0x05, 0x0D, 0x15, 0x1D). 10 rejects 0x15 and write-count-key-data (0x1D). 11 permits all writes.
- R7: The seek field is mask[4:3]. 00 permits full seek (0x07), seek-cylinder (0x08) and seek-head (0x18). 01 permits 0x08 and 0x18. 10 permits only 0x18. 11 rejects all three.
- R8: The seek argument seek_arg[47:0] carries byte 0 in bits [47:40] through byte 5 in bits [7:0]. The cylinder is byte 3 and the head is byte 5. A nonzero value in byte 0, 1, 2 or 4 rejects the seek.
- R9: A seek whose cylinder exceeds cyl_max or whose head exceeds head_max is rejected, whichever seek kind it is.
- R10: A seek with cmd_count below 6 is rejected. A count of 6 or more is accepted, using only the six argument bytes.
- R11: An accepted full seek loads both cylinder and head. Seek-cylinder loads only the cylinder, and seek-head loads only the head.
- R12: A rejected command returns resp_permit 0 and resp_status 0x0200, and cur_cyl and cur_head stay unchanged. An accepted command returns resp_permit 1 and resp_status 0x0000.
- R13: Any other command code is permitted with status 0x0000 and changes neither mask nor position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_start | input | 1 | Start of a new command chain |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_code | input | 8 | Command code |
| cmd_count | input | CNT_W | Byte count of the command |
| seek_arg | input | 48 | Six-byte seek argument, byte 0 in the top bits |
| mask_in | input | 8 | Mask byte for a set-mask command |
| cyl_max | input | 8 | Highest valid cylinder |
| head_max | input | 8 | Highest valid head |
| resp_valid | output | 1 | Decision is valid this cycle |
| resp_permit | output | 1 | 1 = command permitted |
| resp_status | output | 16 | 0x0200 on reject, 0x0000 otherwise |
| cur_cyl | output | 8 | Cylinder currently selected |
| cur_head | output | 8 | Head currently selected |

## Verification
A command driven before an edge has its decision, status and new position registered at that edge, so every result is due exactly one clock after the stimulus. The bench drives inputs on the falling edge and samples all five outputs on the next falling edge. It then drops cmd_valid before the next rising edge. It also samples in idle cycles to confirm that resp_valid stays low with no command. A reference model in the bench advances its mask and position only when a response is sampled, so directed and random commands stay aligned one cycle apart.

// File: rtl/fms_pkg.sv
package fms_pkg;
   localparam int ARG_BYTES = 6;
   localparam int CYL_IDX   = 3;
   localparam int HEAD_IDX  = 5;

   localparam logic [7:0] OP_SEEK_FULL = 8'h07;
   localparam logic [7:0] OP_SEEK_CYL  = 8'h08;
   localparam logic [7:0] OP_SEEK_HEAD = 8'h18;
   localparam logic [7:0] OP_SET_MASK  = 8'h1F;
   localparam logic [7:0] OP_WR_DATA   = 8'h05;
   localparam logic [7:0] OP_WR_KD     = 8'h0D;
   localparam logic [7:0] OP_WR_R0     = 8'h15;
   localparam logic [7:0] OP_WR_CKD    = 8'h1D;

   localparam logic [15:0] ST_UNIT_CHECK = 16'h0200;
   localparam logic [15:0] ST_CLEAN      = 16'h0000;

   typedef enum logic [2:0] {
      K_OTHER,
      K_SEEK_FULL,
      K_SEEK_CYL,
      K_SEEK_HEAD,
      K_SET_MASK,
      K_WRITE
   } cmd_kind_e;

   function automatic cmd_kind_e classify(input logic [7:0] code);
      case (code)
         OP_SEEK_FULL: return K_SEEK_FULL;
         OP_SEEK_CYL:  return K_SEEK_CYL;
         OP_SEEK_HEAD: return K_SEEK_HEAD;
         OP_SET_MASK:  return K_SET_MASK;
         OP_WR_DATA, OP_WR_KD, OP_WR_R0, OP_WR_CKD: return K_WRITE;
         default:      return K_OTHER;
      endcase
   endfunction

   function automatic logic is_seek(input cmd_kind_e k);
      return (k == K_SEEK_FULL) || (k == K_SEEK_CYL) || (k == K_SEEK_HEAD);
   endfunction
endpackage

// File: rtl/fms_mask_reg.sv
module fms_mask_reg
   import fms_pkg::*;
#(
   parameter int MASK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chain_start,
   input  logic              set_req,
   input  logic [MASK_W-1:0] mask_in,
   output logic [MASK_W-1:0] eff_mask,
   output logic              set_ok
);
   generate
      if (MASK_W != 8) begin : g_bad_width
         $error("fms_mask_reg: mask must be one byte");
      end
   endgenerate

   logic [MASK_W-1:0] mask_q;
   logic              set_q;
   logic              eff_set;

   // chain_start acts ahead of a command presented in the same cycle
   assign eff_mask = chain_start ? '0 : mask_q;
   assign eff_set  = chain_start ? 1'b0 : set_q;
   assign set_ok   = !eff_set && !mask_in[5] && !mask_in[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         set_q  <= 1'b0;
      end else if (set_req && set_ok) begin
         mask_q <= mask_in;
         set_q  <= 1'b1;
      end else if (chain_start) begin
         mask_q <= '0;
         set_q  <= 1'b0;
      end
   end

   // R4: once loaded within a chain the mask cannot be overwritten
   p_once_per_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_req && set_q && !chain_start |=> $stable(mask_q));

   // R3: a chain start without a mask load leaves the mask cleared
   p_chain_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chain_start && !set_req |=> mask_q == '0);

   // R5: a mask byte with a reserved bit set never reaches the register
   p_reserved_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_req && (mask_in[5] || mask_in[1]) && !chain_start |=> $stable(mask_q));
endmodule

// File: rtl/fms_seek_check.sv
module fms_seek_check
   import fms_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int MIN_COUNT = ARG_BYTES
) (
   input  logic [8*ARG_BYTES-1:0] seek_arg,
   input  logic [CNT_W-1:0]       count,
   input  cmd_kind_e              kind,
   input  logic [1:0]             seek_field,
   input  logic [7:0]             cyl_max,
   input  logic [7:0]             head_max,
   output logic                   seek_ok,
   output logic [7:0]             cyl_arg,
   output logic [7:0]             head_arg
);
   localparam int ARG_W = 8 * ARG_BYTES;

   generate
      if (CNT_W < 3 || MIN_COUNT >= (1 << CNT_W)) begin : g_bad_count
         $error("fms_seek_check: count width too small for MIN_COUNT");
      end
   endgenerate

   logic [ARG_BYTES-1:0] pad_nz;

   // byte i of the argument sits at the top of the vector for i = 0
   for (genvar i = 0; i < ARG_BYTES; i++) begin : g_byte
      localparam int LSB = ARG_W - 8 * (i + 1);
      if (i == CYL_IDX || i == HEAD_IDX) begin : g_field
         assign pad_nz[i] = 1'b0;
      end else begin : g_pad
         assign pad_nz[i] = |seek_arg[LSB +: 8];
      end
   end

   assign cyl_arg  = seek_arg[ARG_W - 8 * (CYL_IDX + 1)  +: 8];
   assign head_arg = seek_arg[ARG_W - 8 * (HEAD_IDX + 1) +: 8];

   logic count_ok;
   logic range_ok;
   logic kind_ok;

   assign count_ok = count >= CNT_W'(MIN_COUNT);
   assign range_ok = (cyl_arg <= cyl_max) && (head_arg <= head_max);

   always_comb begin
      unique case (seek_field)
         2'b00:   kind_ok = 1'b1;
         2'b01:   kind_ok = (kind != K_SEEK_FULL);
         2'b10:   kind_ok = (kind == K_SEEK_HEAD);
         default: kind_ok = 1'b0;
      endcase
   end

   assign seek_ok = count_ok && range_ok && (pad_nz == '0) && kind_ok;
endmodule

// File: rtl/fms_write_gate.sv
module fms_write_gate
   import fms_pkg::*;
(
   input  logic [7:0] code,
   input  logic [1:0] write_field,
   output logic       write_ok
);
   logic is_r0;
   logic is_fmt;

   assign is_r0  = (code == OP_WR_R0);
   assign is_fmt = (code == OP_WR_R0) || (code == OP_WR_CKD);

   always_comb begin
      unique case (write_field)
         2'b00:   write_ok = !is_r0;
         2'b01:   write_ok = 1'b0;
         2'b10:   write_ok = !is_fmt;
         default: write_ok = 1'b1;
      endcase
   end
endmodule

// File: rtl/fms_validator.sv
module fms_validator
   import fms_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int MIN_COUNT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chain_start,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_code,
   input  logic [CNT_W-1:0] cmd_count,
   input  logic [47:0]      seek_arg,
   input  logic [7:0]       mask_in,
   input  logic [7:0]       cyl_max,
   input  logic [7:0]       head_max,
   output logic             resp_valid,
   output logic             resp_permit,
   output logic [15:0]      resp_status,
   output logic [7:0]       cur_cyl,
   output logic [7:0]       cur_head
);
   localparam int WF_HI = 7;
   localparam int SF_HI = 4;

   generate
      if (MIN_COUNT != ARG_BYTES) begin : g_bad_min
         $error("fms_validator: MIN_COUNT must equal the argument length");
      end
   endgenerate

   cmd_kind_e  kind;
   logic [7:0] eff_mask;
   logic       set_ok;
   logic       seek_ok;
   logic       write_ok;
   logic [7:0] cyl_arg;
   logic [7:0] head_arg;
   logic       permit;

   assign kind = classify(cmd_code);

   fms_mask_reg #(.MASK_W(8)) u_mask (
      .clk         (clk),
      .rst_n       (rst_n),
      .chain_start (chain_start),
      .set_req     (cmd_valid && (kind == K_SET_MASK)),
      .mask_in     (mask_in),
      .eff_mask    (eff_mask),
      .set_ok      (set_ok)
   );

   fms_seek_check #(.CNT_W(CNT_W), .MIN_COUNT(MIN_COUNT)) u_seek (
      .seek_arg   (seek_arg),
      .count      (cmd_count),
      .kind       (kind),
      .seek_field (eff_mask[SF_HI -: 2]),
      .cyl_max    (cyl_max),
      .head_max   (head_max),
      .seek_ok    (seek_ok),
      .cyl_arg    (cyl_arg),
      .head_arg   (head_arg)
   );

   fms_write_gate u_write (
      .code        (cmd_code),
      .write_field (eff_mask[WF_HI -: 2]),
      .write_ok    (write_ok)
   );

   always_comb begin
      unique case (kind)
         K_SEEK_FULL, K_SEEK_CYL, K_SEEK_HEAD: permit = seek_ok;
         K_SET_MASK:                           permit = set_ok;
         K_WRITE:                              permit = write_ok;
         default:                              permit = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid  <= 1'b0;
         resp_permit <= 1'b0;
         resp_status <= ST_CLEAN;
         cur_cyl     <= '0;
         cur_head    <= '0;
      end else begin
         resp_valid <= cmd_valid;
         if (cmd_valid) begin
            resp_permit <= permit;
            resp_status <= permit ? ST_CLEAN : ST_UNIT_CHECK;
            if (permit && (kind == K_SEEK_FULL || kind == K_SEEK_CYL))
               cur_cyl <= cyl_arg;
            if (permit && (kind == K_SEEK_FULL || kind == K_SEEK_HEAD))
               cur_head <= head_arg;
         end
      end
   end

   // R2: one response per command, one cycle later
   p_resp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> resp_valid);
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !resp_valid);

   // R12: a rejected command leaves the position untouched
   p_hold_on_reject_r12: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_permit |-> $stable(cur_cyl) && $stable(cur_head));

   // R10: short seek counts are refused
   p_short_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && is_seek(kind) && (cmd_count < CNT_W'(MIN_COUNT)) |=> !resp_permit);

   // R9: out-of-range cylinder or head is refused
   p_limits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && is_seek(kind) && (cyl_arg > cyl_max || head_arg > head_max)
      |=> !resp_permit);

   // R11: seek-head never moves the arm, seek-cylinder never switches heads
   p_head_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && kind == K_SEEK_HEAD |=> $stable(cur_cyl));
   p_cyl_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && kind == K_SEEK_CYL |=> $stable(cur_head));

   // R6: write field 01 refuses every write
   p_inhibit_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && kind == K_WRITE && eff_mask[WF_HI -: 2] == 2'b01 |=> !resp_permit);

   // R7: seek field 11 refuses every seek
   p_inhibit_seeks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && is_seek(kind) && eff_mask[SF_HI -: 2] == 2'b11 |=> !resp_permit);
endmodule

// File: tb/fms_validator_test.sv
module fms_validator_test;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             chain_start = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [7:0]       cmd_code = '0;
   logic [CNT_W-1:0] cmd_count = '0;
   logic [47:0]      seek_arg = '0;
   logic [7:0]       mask_in = '0;
   logic [7:0]       cyl_max = 8'd19;
   logic [7:0]       head_max = 8'd3;
   logic             resp_valid;
   logic             resp_permit;
   logic [15:0]      resp_status;
   logic [7:0]       cur_cyl;
   logic [7:0]       cur_head;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_mask = '0;
   logic       m_set  = 1'b0;
   logic [7:0] m_cyl  = '0;
   logic [7:0] m_head = '0;

   always #10 clk = ~clk;

   fms_validator #(.CNT_W(CNT_W), .MIN_COUNT(6)) uut (
      .clk(clk), .rst_n(rst_n), .chain_start(chain_start), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_count(cmd_count), .seek_arg(seek_arg),
      .mask_in(mask_in), .cyl_max(cyl_max), .head_max(head_max),
      .resp_valid(resp_valid), .resp_permit(resp_permit), .resp_status(resp_status),
      .cur_cyl(cur_cyl), .cur_head(cur_head)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [47:0] mk_arg(input logic [7:0] cc, input logic [7:0] hh);
      return {24'h0, cc, 8'h00, hh};
   endfunction

   // reference model: returns the expected decision and advances model state
   task automatic model(input logic [7:0] code, input logic [15:0] cnt,
                        input logic [47:0] arg, input logic [7:0] mk,
                        input logic chain, output logic ok);
      logic [7:0] em;
      logic       es;
      logic [7:0] cc;
      logic [7:0] hh;
      logic       argok;
      em = chain ? 8'h00 : m_mask;
      es = chain ? 1'b0 : m_set;
      m_mask = em;
      m_set  = es;
      cc = arg[23:16];
      hh = arg[7:0];
      argok = (cnt >= 16'd6) && (arg[47:24] == 24'h0) && (arg[15:8] == 8'h0)
              && (cc <= cyl_max) && (hh <= head_max);
      case (code)
         8'h1F: begin
            ok = !es && !mk[5] && !mk[1];
            if (ok) begin m_mask = mk; m_set = 1'b1; end
         end
         8'h07: ok = argok && (em[4:3] == 2'b00);
         8'h08: ok = argok && (em[4:3] == 2'b00 || em[4:3] == 2'b01);
         8'h18: ok = argok && (em[4:3] != 2'b11);
         8'h05, 8'h0D, 8'h15, 8'h1D: begin
            case (em[7:6])
               2'b00:   ok = (code != 8'h15);
               2'b01:   ok = 1'b0;
               2'b10:   ok = (code != 8'h15) && (code != 8'h1D);
               default: ok = 1'b1;
            endcase
         end
         default: ok = 1'b1;
      endcase
      if (ok && (code == 8'h07 || code == 8'h08)) m_cyl = cc;
      if (ok && (code == 8'h07 || code == 8'h18)) m_head = hh;
   endtask

   // called at a falling edge; the result is sampled at the next falling edge
   task automatic issue(input string req, input logic [7:0] code,
                        input logic [15:0] cnt, input logic [47:0] arg,
                        input logic [7:0] mk, input logic chain);
      logic ok;
      model(code, cnt, arg, mk, chain, ok);
      chain_start = chain;
      cmd_valid   = 1'b1;
      cmd_code    = code;
      cmd_count   = cnt;
      seek_arg    = arg;
      mask_in     = mk;
      @(negedge clk);
      cmd_valid   = 1'b0;
      chain_start = 1'b0;
      check(req, "resp_valid", 16'(resp_valid), 16'h1);
      check(req, "permit", 16'(resp_permit), 16'(ok));
      check(req, "status", resp_status, ok ? 16'h0000 : 16'h0200);
      check(req, "cur_cyl", 16'(cur_cyl), 16'(m_cyl));
      check(req, "cur_head", 16'(cur_head), 16'(m_head));
   endtask

   task automatic idle(input string req);
      @(negedge clk);
      check(req, "resp_valid idle", 16'(resp_valid), 16'h0);
      check(req, "cur_cyl idle", 16'(cur_cyl), 16'(m_cyl));
      check(req, "cur_head idle", 16'(cur_head), 16'(m_head));
   endtask

   initial begin
      #(20 * 50000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "resp_valid", 16'(resp_valid), 16'h0);
      check("R1", "cur_cyl", 16'(cur_cyl), 16'h0);
      check("R1", "cur_head", 16'(cur_head), 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      idle("R2");
      // R1: reset mask is 0x00, so write-R0 is refused and a full seek is allowed
      issue("R1", 8'h15, 16'd20, '0, '0, 1'b0);
      issue("R1", 8'h07, 16'd6, mk_arg(8'd5, 8'd2), '0, 1'b0);
      idle("R2");
      // R11: partial seeks
      issue("R11", 8'h08, 16'd6, mk_arg(8'd9, 8'd1), '0, 1'b0);
      issue("R11", 8'h18, 16'd6, mk_arg(8'd1, 8'd3), '0, 1'b0);
      // R10: short and long counts
      issue("R10", 8'h07, 16'd5, mk_arg(8'd3, 8'd0), '0, 1'b0);
      issue("R10", 8'h07, 16'd40, mk_arg(8'd3, 8'd0), '0, 1'b0);
      // R8: nonzero pad bytes
      issue("R8", 8'h07, 16'd6, 48'h01_00_00_04_00_01, '0, 1'b0);
      issue("R8", 8'h18, 16'd6, 48'h00_00_00_04_80_01, '0, 1'b0);
      // R9: limits, boundary values accepted, one past refused
      issue("R9", 8'h07, 16'd6, mk_arg(8'd19, 8'd3), '0, 1'b0);
      issue("R9", 8'h18, 16'd6, mk_arg(8'd20, 8'd0), '0, 1'b0);
      issue("R9", 8'h08, 16'd6, mk_arg(8'd0, 8'd4), '0, 1'b0);
      // R5: reserved bits refused, then a good mask: writes 01, seek field 10
      issue("R5", 8'h1F, 16'd1, '0, 8'h20, 1'b0);
      issue("R5", 8'h1F, 16'd1, '0, 8'h02, 1'b0);
      issue("R5", 8'h1F, 16'd1, '0, 8'h50, 1'b0);
      // R6 / R7 under mask 0x50
      issue("R6", 8'h05, 16'd8, '0, '0, 1'b0);
      issue("R7", 8'h08, 16'd6, mk_arg(8'd2, 8'd2), '0, 1'b0);
      issue("R7", 8'h18, 16'd6, mk_arg(8'd2, 8'd2), '0, 1'b0);
      // R4: second load in the chain refused, mask still 0x50
      issue("R4", 8'h1F, 16'd1, '0, 8'hC0, 1'b0);
      issue("R4", 8'h0D, 16'd8, '0, '0, 1'b0);
      // R3: chain start in same cycle as a load; then mask 0x88 (writes 10, seek 01)
      issue("R3", 8'h1F, 16'd1, '0, 8'h88, 1'b1);
      issue("R6", 8'h1D, 16'd8, '0, '0, 1'b0);
      issue("R6", 8'h0D, 16'd8, '0, '0, 1'b0);
      issue("R7", 8'h07, 16'd6, mk_arg(8'd1, 8'd1), '0, 1'b0);
      issue("R7", 8'h08, 16'd6, mk_arg(8'd1, 8'd1), '0, 1'b0);
      // R3: chain start with a write resets the mask to 0x00
      issue("R3", 8'h15, 16'd8, '0, '0, 1'b1);
      issue("R3", 8'h1D, 16'd8, '0, '0, 1'b0);
      // R7: seek field 11 (mask 0xD8) refuses all, write field 11 permits all
      issue("R7", 8'h1F, 16'd1, '0, 8'hD8, 1'b1);
      issue("R7", 8'h18, 16'd6, mk_arg(8'd0, 8'd0), '0, 1'b0);
      issue("R6", 8'h15, 16'd8, '0, '0, 1'b0);
      // R13: other codes pass and change nothing
      issue("R13", 8'h06, 16'd3, 48'hFFFF_FFFF_FFFF, 8'hFF, 1'b0);
      issue("R13", 8'h29, 16'd0, '0, '0, 1'b0);
      issue("R12", 8'h07, 16'd6, mk_arg(8'd7, 8'd1), '0, 1'b0);
      idle("R2");
      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [7:0]  code;
         logic [15:0] cnt;
         logic [47:0] arg;
         logic [7:0]  mk;
         logic        chain;
         case ($urandom % 10)
            0: code = 8'h07; 1: code = 8'h08; 2: code = 8'h18; 3: code = 8'h1F;
            4: code = 8'h05; 5: code = 8'h0D; 6: code = 8'h15; 7: code = 8'h1D;
            8: code = 8'h06; default: code = 8'h29;
         endcase
         cnt = ($urandom % 4 == 0) ? 16'($urandom % 8) : 16'(6 + $urandom % 4);
         if ($urandom % 4 != 0)
            arg = mk_arg(8'($urandom % 21), 8'($urandom % 5));
         else
            arg = {$urandom, 16'($urandom)};
         mk = 8'($urandom);
         if ($urandom % 4 != 0) mk = mk & 8'hDD;
         chain = ($urandom % 6 == 0);
         if (n == 300) begin cyl_max = 8'd199; head_max = 8'd19; end
         issue("R12", code, cnt, arg, mk, chain);
         if ($urandom % 8 == 0) idle("R2");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule